// File: doc/BRIEF.md
# Address Write-Protect Register Unit

This unit sits beside the command engine of a serial non-volatile memory and decides whether each program or erase request may go ahead. It holds one protect threshold. While the threshold is active, any word-level write or erase that targets an address at or above it is refused. The whole-array operations are refused whenever any threshold is active.

The threshold can only be changed through an arming step that must come directly before the change. A one-time seal instruction freezes the threshold until a global reset, which stands in for a factory-fresh part. A register-read instruction returns the stored threshold as a frame led by a zero bit.

The command engine presents one decoded instruction per cycle, together with the two pin levels sampled while it was loaded and the current write-enable state. One cycle later the unit answers with exactly one of grant or abort.

Top module: `wp_guard`

## Requirements
- R1: After reset the threshold is inactive, the unit is unsealed and disarmed, and all outputs are low. A register read then returns the frame 0x0FF: a zero lead bit followed by the all-ones address.
- R2: An instruction with `cmd_op` 1 to 9 gets exactly one of `resp_ok` or `resp_abort` high in the cycle after it is presented. Code 0 (any other instruction) and idle cycles produce neither.
- R3: Word write (code 1) and word erase (code 2) are granted only when `wren_state` is high, `pre_lvl` is low and `pe_lvl` is high, and either the threshold is inactive or the target is strictly below it. A target equal to the threshold aborts, and an active threshold of 0 blocks every address.
- R4: Erase-all (code 3) and write-all (code 4) need the same pin conditions as R3 and are granted only while the threshold is inactive.
- R5: Arm (code 5) is granted only with `wren_state`, `pre_lvl` and `pe_lvl` all high.
- R6: Clear (code 6), set (code 7) and seal (code 8) are granted only when the instruction directly before was a granted arm, with `pre_lvl` and `pe_lvl` high, and with the unit unsealed. Any other instruction, including code 0 or a refused arm, disarms the unit.
- R7: Set is granted only while the threshold is inactive. It loads `cmd_addr` and makes the threshold active.
- R8: Clear makes the threshold inactive and sets the stored address to all ones.
- R9: A granted seal is permanent until reset. Afterwards clear, set and seal are always refused, and the threshold keeps its value.
- R10: Register read (code 9) with `pre_lvl` high is granted and pulses `rd_stb` with `rd_frame` = {0, stored address}. With `pre_lvl` low it aborts and `rd_stb` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low global reset (also clears the seal) |
| cmd_valid | input | 1 | An instruction is presented this cycle |
| cmd_op | input | 4 | Instruction code, see requirements |
| cmd_addr | input | ADDR_W | Target address or new threshold |
| pre_lvl | input | 1 | Protect-select pin level during loading |
| pe_lvl | input | 1 | Program-enable pin level during loading |
| wren_state | input | 1 | Write-enable state of the command engine |
| resp_ok | output | 1 | Instruction granted (one cycle pulse) |
| resp_abort | output | 1 | Instruction refused (one cycle pulse) |
| rd_stb | output | 1 | Register read frame valid |
| rd_frame | output | ADDR_W+1 | Zero lead bit followed by the stored address |

## Verification
The hardest situation to reach is an arming that gets broken by an instruction which changes nothing visible. Examples are a code-0 instruction or a refused arm placed between a granted arm and a clear. The stimulus builds these back-to-back sequences directly, so that every instruction hits its own clock edge.

A second hard case is a sealed unit whose threshold must stay fixed through repeated arm, clear and set attempts. The bench follows these attempts with word writes on both sides of the threshold and a register read. A threshold of 0 is also loaded, to show that the active flag and not the address value decides protection.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [3:0] {
    OP_OTHER = 4'd0,
    OP_WRITE = 4'd1,
    OP_ERASE = 4'd2,
    OP_ERALL = 4'd3,
    OP_WRALL = 4'd4,
    OP_ARM   = 4'd5,
    OP_CLEAR = 4'd6,
    OP_SET   = 4'd7,
    OP_SEAL  = 4'd8,
    OP_RDREG = 4'd9
  } wp_op_e;

  typedef struct packed {
    logic prog_word;
    logic prog_all;
    logic arm;
    logic clr;
    logic set;
    logic seal;
    logic rdreg;
    logic other;
  } wp_cls_t;

  // true when a target lies outside the protected range
  function automatic logic below_fence(int unsigned tgt, int unsigned fence, logic fence_on);
    return !fence_on || (tgt < fence);
  endfunction
endpackage

// File: rtl/wp_decode.sv
module wp_decode
  import wp_pkg::*;
(
  input  logic       cmd_valid,
  input  logic [3:0] cmd_op,
  output wp_cls_t    cls
);
  always_comb begin
    cls = '0;
    if (cmd_valid) begin
      case (cmd_op)
        OP_WRITE, OP_ERASE: cls.prog_word = 1'b1;
        OP_ERALL, OP_WRALL: cls.prog_all  = 1'b1;
        OP_ARM:             cls.arm       = 1'b1;
        OP_CLEAR:           cls.clr       = 1'b1;
        OP_SET:             cls.set       = 1'b1;
        OP_SEAL:            cls.seal      = 1'b1;
        OP_RDREG:           cls.rdreg     = 1'b1;
        default:            cls.other     = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/wp_arm_seq.sv
module wp_arm_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_any,
  input  logic arm_ok,
  input  logic seal_ok,
  output logic armed,
  output logic sealed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      sealed <= 1'b0;
    end else begin
      if (cmd_any) armed <= arm_ok;
      if (seal_ok) sealed <= 1'b1;
    end
  end
endmodule

// File: rtl/wp_store.sv
module wp_store #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_ok,
  input  logic              set_ok,
  input  logic [ADDR_W-1:0] set_addr,
  output logic [ADDR_W-1:0] prot_q,
  output logic              prot_valid
);
  localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q     <= ALL_ONES;
      prot_valid <= 1'b0;
    end else if (clr_ok) begin
      prot_q     <= ALL_ONES;
      prot_valid <= 1'b0;
    end else if (set_ok) begin
      prot_q     <= set_addr;
      prot_valid <= 1'b1;
    end
  end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              pre_lvl,
  input  logic              pe_lvl,
  input  logic              wren_state,
  output logic              resp_ok,
  output logic              resp_abort,
  output logic              rd_stb,
  output logic [ADDR_W:0]   rd_frame
);
  localparam int FRAME_W = ADDR_W + 1;

  wp_cls_t           cls;
  logic              armed, sealed;
  logic [ADDR_W-1:0] prot_q;
  logic              prot_valid;

  // named internal events
  logic pin_prog, pin_prot, chg_ok;
  logic arm_ok, clr_ok, set_ok, seal_ok, word_ok, all_ok, rd_ok;
  logic grant, answered;

  wp_decode u_dec (.cmd_valid(cmd_valid), .cmd_op(cmd_op), .cls(cls));

  assign pin_prog = wren_state && !pre_lvl && pe_lvl;
  assign pin_prot = pre_lvl && pe_lvl;
  assign chg_ok   = armed && pin_prot && !sealed;

  assign arm_ok  = cls.arm && wren_state && pin_prot;
  assign clr_ok  = cls.clr && chg_ok;
  assign set_ok  = cls.set && chg_ok && !prot_valid;
  assign seal_ok = cls.seal && chg_ok;
  assign word_ok = cls.prog_word && pin_prog &&
                   below_fence(int'(cmd_addr), int'(prot_q), prot_valid);
  assign all_ok  = cls.prog_all && pin_prog && !prot_valid;
  assign rd_ok   = cls.rdreg && pre_lvl;

  assign grant    = arm_ok || clr_ok || set_ok || seal_ok || word_ok || all_ok || rd_ok;
  assign answered = cmd_valid && !cls.other;

  wp_arm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_any(cmd_valid),
    .arm_ok(arm_ok), .seal_ok(seal_ok), .armed(armed), .sealed(sealed)
  );

  wp_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr_ok(clr_ok), .set_ok(set_ok),
    .set_addr(cmd_addr), .prot_q(prot_q), .prot_valid(prot_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_ok    <= 1'b0;
      resp_abort <= 1'b0;
      rd_stb     <= 1'b0;
      rd_frame   <= '0;
    end else begin
      resp_ok    <= grant;
      resp_abort <= answered && !grant;
      rd_stb     <= rd_ok;
      if (rd_ok) rd_frame <= FRAME_W'({1'b0, prot_q});
    end
  end
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [3:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              resp_ok,
  input logic              resp_abort,
  input logic              rd_stb,
  input logic [ADDR_W:0]   rd_frame,
  input logic              armed,
  input logic              sealed,
  input logic [ADDR_W-1:0] prot_q,
  input logic              prot_valid,
  input logic              set_ok
);
  assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_ok && resp_abort));

  assert_answered_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op != 4'd0) |=> (resp_ok || resp_abort));

  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid || cmd_op == 4'd0) |=> (!resp_ok && !resp_abort && !rd_stb));

  assert_fence_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 4'd1 || cmd_op == 4'd2) && prot_valid && cmd_addr >= prot_q)
      |=> resp_abort);

  assert_all_needs_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 4'd3 || cmd_op == 4'd4) && prot_valid) |=> !resp_ok);

  assert_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op != 4'd5) |=> !armed);

  assert_set_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_ok |=> (prot_valid && prot_q == $past(cmd_addr)));

  assert_seal_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sealed |=> sealed);

  assert_sealed_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sealed |=> ($stable(prot_q) && $stable(prot_valid)));

  assert_frame_lead_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> !rd_frame[ADDR_W]);
endmodule

bind wp_guard wp_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_addr(cmd_addr), .resp_ok(resp_ok), .resp_abort(resp_abort),
  .rd_stb(rd_stb), .rd_frame(rd_frame), .armed(armed), .sealed(sealed),
  .prot_q(prot_q), .prot_valid(prot_valid), .set_ok(set_ok)
);

// File: tb/wp_guard_test.sv
module wp_guard_test;
  localparam int AW = 8;
  localparam int MAXA = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [3:0] cmd_op = 4'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic pre_lvl = 1'b0, pe_lvl = 1'b0, wren_state = 1'b0;
  logic resp_ok, resp_abort, rd_stb;
  logic [AW:0] rd_frame;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference model state
  bit m_armed = 0, m_sealed = 0, m_valid = 0;
  int m_addr = MAXA;
  bit e_ok = 0, e_ab = 0, e_rd = 0;
  int e_frame = 0;
  string cur_tag = "R1";
  string e_tag = "R1";

  always #10 clk = ~clk;

  wp_guard #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .pre_lvl(pre_lvl), .pe_lvl(pe_lvl),
    .wren_state(wren_state), .resp_ok(resp_ok), .resp_abort(resp_abort),
    .rd_stb(rd_stb), .rd_frame(rd_frame)
  );

  always @(posedge clk) begin
    bit g;
    e_tag = cur_tag;
    if (!rst_n) begin
      m_armed = 0; m_sealed = 0; m_valid = 0; m_addr = MAXA;
      e_ok = 0; e_ab = 0; e_rd = 0;
    end else begin
      g = 0;
      e_rd = 0;
      if (cmd_valid) begin
        case (int'(cmd_op))
          1, 2: g = wren_state && !pre_lvl && pe_lvl &&
                    (!m_valid || int'(cmd_addr) < m_addr);
          3, 4: g = wren_state && !pre_lvl && pe_lvl && !m_valid;
          5:    g = wren_state && pre_lvl && pe_lvl;
          6: if (m_armed && pre_lvl && pe_lvl && !m_sealed) begin
               g = 1; m_valid = 0; m_addr = MAXA;
             end
          7: if (m_armed && pre_lvl && pe_lvl && !m_sealed && !m_valid) begin
               g = 1; m_valid = 1; m_addr = int'(cmd_addr);
             end
          8: if (m_armed && pre_lvl && pe_lvl && !m_sealed) begin
               g = 1; m_sealed = 1;
             end
          9: if (pre_lvl) begin
               g = 1; e_rd = 1; e_frame = m_addr;
             end
          default: g = 0;
        endcase
        m_armed = (cmd_op == 4'd5) && g;
      end
      e_ok = g;
      e_ab = cmd_valid && cmd_op >= 4'd1 && cmd_op <= 4'd9 && !g;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (resp_ok !== e_ok || resp_abort !== e_ab || rd_stb !== e_rd) begin
        errors++;
        $display("FAIL %s: ok/abort/rd = %b%b%b expected %b%b%b at %0t",
                 e_tag, resp_ok, resp_abort, rd_stb, e_ok, e_ab, e_rd, $time);
      end
      if (e_rd) begin
        checks++;
        if (rd_frame !== (AW+1)'(e_frame)) begin
          errors++;
          $display("FAIL %s: rd_frame = %h expected %h", e_tag, rd_frame, e_frame);
        end
      end
    end
  end

  task automatic issue(input int op, input int addr, input bit pre, input bit pe,
                       input bit wr, input string tag);
    @(negedge clk);
    cur_tag    = tag;
    cmd_valid  = 1'b1;
    cmd_op     = 4'(op);
    cmd_addr   = AW'(addr);
    pre_lvl    = pre;
    pe_lvl     = pe;
    wren_state = wr;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cur_tag = tag;
      cmd_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    cmd_valid = 1'b0;
    cur_tag = "R1";
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2, "R1");
    // R1: fresh readout and unprotected write
    issue(9, 0, 1, 0, 0, "R1");
    issue(1, 8'hFF, 0, 1, 1, "R1");
    // R2: other instruction and idle are silent
    issue(0, 0, 1, 1, 1, "R2");
    idle(2, "R2");
    // R5: arm conditions
    issue(5, 0, 1, 1, 0, "R5");
    issue(5, 0, 0, 1, 1, "R5");
    issue(5, 0, 1, 0, 1, "R5");
    issue(5, 0, 1, 1, 1, "R5");
    // R6: broken arming
    issue(0, 0, 1, 1, 1, "R6");
    issue(6, 0, 1, 1, 1, "R6");
    issue(5, 0, 1, 1, 1, "R6");
    issue(5, 0, 1, 1, 0, "R6");
    issue(7, 8'h10, 1, 1, 1, "R6");
    issue(5, 0, 1, 1, 1, "R6");
    issue(6, 0, 1, 0, 1, "R6");
    issue(7, 8'h10, 1, 1, 1, "R6");
    // R7: set threshold 0x40, second set refused
    issue(5, 0, 1, 1, 1, "R7");
    issue(7, 8'h40, 1, 1, 1, "R7");
    issue(5, 0, 1, 1, 1, "R7");
    issue(7, 8'h20, 1, 1, 1, "R7");
    issue(9, 0, 1, 0, 0, "R7");
    // R3: fence at 0x40
    issue(1, 8'h3F, 0, 1, 1, "R3");
    issue(1, 8'h40, 0, 1, 1, "R3");
    issue(2, 8'h41, 0, 1, 1, "R3");
    issue(2, 8'h00, 0, 1, 1, "R3");
    issue(1, 8'h01, 1, 1, 1, "R3");
    issue(1, 8'h01, 0, 1, 0, "R3");
    issue(1, 8'h01, 0, 0, 1, "R3");
    // R4: array ops blocked while active
    issue(3, 0, 0, 1, 1, "R4");
    issue(4, 0, 0, 1, 1, "R4");
    // R8: clear
    issue(5, 0, 1, 1, 1, "R8");
    issue(6, 0, 1, 1, 1, "R8");
    issue(9, 0, 1, 1, 1, "R8");
    issue(1, 8'hFF, 0, 1, 1, "R8");
    issue(3, 0, 0, 1, 1, "R4");
    issue(4, 0, 0, 1, 1, "R4");
    issue(4, 0, 0, 0, 1, "R4");
    issue(3, 0, 1, 1, 1, "R4");
    // R3: threshold zero blocks everything
    issue(5, 0, 1, 1, 1, "R3");
    issue(7, 8'h00, 1, 1, 1, "R3");
    issue(1, 8'h00, 0, 1, 1, "R3");
    issue(2, 8'hFF, 0, 1, 1, "R3");
    issue(9, 0, 1, 0, 0, "R3");
    issue(5, 0, 1, 1, 1, "R8");
    issue(6, 0, 1, 1, 1, "R8");
    // R9: seal at 0x80
    issue(5, 0, 1, 1, 1, "R9");
    issue(7, 8'h80, 1, 1, 1, "R9");
    issue(5, 0, 1, 1, 1, "R9");
    issue(8, 0, 1, 1, 1, "R9");
    issue(5, 0, 1, 1, 1, "R9");
    issue(6, 0, 1, 1, 1, "R9");
    issue(5, 0, 1, 1, 1, "R9");
    issue(7, 8'h10, 1, 1, 1, "R9");
    issue(5, 0, 1, 1, 1, "R9");
    issue(8, 0, 1, 1, 1, "R9");
    issue(1, 8'h7F, 0, 1, 1, "R9");
    issue(1, 8'h80, 0, 1, 1, "R9");
    issue(9, 0, 1, 0, 0, "R9");
    // R10: read with selector low aborts
    issue(9, 0, 0, 1, 1, "R10");
    idle(2, "R10");
    // R1: reset removes the seal
    do_reset();
    idle(1, "R1");
    issue(9, 0, 1, 0, 0, "R1");
    issue(5, 0, 1, 1, 1, "R1");
    issue(7, 8'h33, 1, 1, 1, "R1");
    issue(9, 0, 1, 1, 1, "R10");
    issue(1, 8'h32, 0, 1, 1, "R3");
    idle(3, "R2");
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule